// File: doc/BRIEF.md
# Subvector Pack/Unpack Move Sequencer

This block runs a vector register move in which only one operand is viewed as a run of short subvectors of 1 to 4 elements, while the other is a flat vector. In gather mode the source is grouped. Each iteration packs one group of narrow source elements into a single destination element. In scatter mode the destination is grouped. Each iteration splits one source element across a group of narrow destination elements. When both widths are equal, only the first member of each group is moved, so the grouped side is strided by the subvector length.

A single start pulse hands over the whole job. The job is a vector length, a subvector length, a mode bit, two base register indices, two element width codes and a per-iteration predicate mask. The sequencer then walks the job one element per clock. It uses one combinational read port and one byte-enabled write port into a file of 32-bit registers. It signals busy for the length of the job and ends it with a one-cycle done pulse.

Top module: `subvec_move_seq`

## Requirements
- R1: After reset, `busy`, `done` and `wr_en` are low.
- R2: In gather mode (`mode`=0), iteration i packs the source elements i*S+j into destination element i, where S = `sub_len_m1`+1. Member j is placed at bit j*sw, where sw is the source width. Only members that fit inside the destination width are taken, so equal widths copy source element i*S alone.
- R3: In scatter mode (`mode`=1), iteration i reads source element i and writes slice j (bits j*dw upward, where dw is the destination width) to destination element i*S+j. Only slices that lie inside the source width are written, so equal widths write destination element i*S alone.
- R4: When a packed group is narrower than the destination element, the unused upper byte lanes of that element are written as zero. For example, three 8-bit members into a 32-bit element give a zero top byte, and the whole element is byte-enabled.
- R5: A source element wider than the destination is truncated to its low bits. A narrower one that is moved alone is zero-extended.
- R6: An iteration whose bit in `pred_mask` (bit i for iteration i) is clear writes nothing and takes exactly one cycle. An active iteration takes one cycle per member or slice it moves.
- R7: `busy` rises the cycle after the accepted start and stays high for steps+1 cycles, where steps is the cycle total from R6. `done` is a one-cycle pulse in the cycle after `busy` falls. Writes occur only while `busy` is high. A vector length of 0 gives steps = 0 and no write.
- R8: With `sub_len_m1`=0 both modes copy element i to element i, zero-extending or truncating between widths.
- R9: A start pulse while `busy` is high is ignored and does not change the running job or its result.
- R10: Width codes are 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, and 3 is treated as 32 bits. Element e of width w bytes lies at byte offset e*w from the base register. Its register is base + offset/4 (modulo the file size) and its byte lane is offset mod 4. Each write enables exactly the w lanes of its element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| vec_len | input | $clog2(MAXVL+1) | Number of iterations |
| sub_len_m1 | input | 2 | Subvector length minus one |
| mode | input | 1 | 0 = source grouped (gather), 1 = destination grouped (scatter) |
| src_base | input | RAW | Source base register index |
| dst_base | input | RAW | Destination base register index |
| src_ew | input | 2 | Source element width code |
| dst_ew | input | 2 | Destination element width code |
| pred_mask | input | MAXVL | Predicate, bit i enables iteration i |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_reg | output | RAW | Read port register index |
| rd_data | input | 32 | Read data, combinational from `rd_reg` |
| wr_en | output | 1 | Write strobe |
| wr_reg | output | RAW | Write register index |
| wr_be | output | 4 | Write byte enables |
| wr_data | output | 32 | Write data, already shifted to its lanes |

## Verification
The start is sampled on a clock edge, and each step reads the source in the same cycle. The write that a step produces appears on the write port one cycle later, and `done` follows exactly steps+1 edges after the start edge. The bench drives and samples on the falling edge. It counts falling edges from the start until `done`, and expects `done` at count steps+2, `busy` on steps+1 samples and one `wr_en` sample per expected write. It compares the whole register file against a reference computed from the pre-job contents once `done` is seen.

// File: rtl/svm_pkg.sv
`timescale 1ns/1ps
// svm_pkg: shared types and width helpers for the subvector move sequencer.
// Assumes 32-bit registers made of four byte lanes.
package svm_pkg;
    localparam int REG_BYTES = 4;
    localparam logic MODE_GATHER  = 1'b0;
    localparam logic MODE_SCATTER = 1'b1;

    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_DRAIN = 2'd2} seq_state_e;

    // Clamp a width code to its log2 byte count (code 3 acts as 32 bits).
    function automatic logic [1:0] ew_log(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

    // Byte enables of one element of the given log2 byte width at lane 0.
    function automatic logic [3:0] ew_be(input logic [1:0] lg);
        case (lg)
            2'd0:    return 4'b0001;
            2'd1:    return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    // Value mask of one element of the given log2 byte width.
    function automatic logic [31:0] ew_mask(input logic [1:0] lg);
        case (lg)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/svm_addr.sv
`timescale 1ns/1ps
// svm_addr: maps an element index of a given width to a register and byte lane.
// Assumes elements are naturally aligned, so one never straddles two registers.
module svm_addr #(
    parameter int RAW  = 7,
    parameter int IDXW = 5
) (
    input  logic [RAW-1:0]  base,
    input  logic [IDXW-1:0] idx,
    input  logic [1:0]      ewl,
    output logic [RAW-1:0]  reg_idx,
    output logic [1:0]      lane
);
    localparam int OFFW = IDXW + 2;
    logic [OFFW-1:0] off;

    // Byte offset from the base, split into register step and lane.
    always_comb begin
        off     = {2'b00, idx} << ewl;
        reg_idx = base + RAW'(off >> 2);
        lane    = off[1:0];
    end
endmodule

// File: rtl/svm_ctrl.sv
`timescale 1ns/1ps
// svm_ctrl: latches the job on start and walks iterations and sub-steps.
// Assumes MAXVL >= 2; one sub-step per cycle, a drain cycle for the last write.
module svm_ctrl
    import svm_pkg::*;
#(
    parameter int MAXVL = 8,
    parameter int RAW   = 7,
    parameter int VLW   = 4,
    parameter int IW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VLW-1:0]   vec_len,
    input  logic [1:0]       sub_len_m1,
    input  logic             mode,
    input  logic [RAW-1:0]   src_base,
    input  logic [RAW-1:0]   dst_base,
    input  logic [1:0]       src_ew,
    input  logic [1:0]       dst_ew,
    input  logic [MAXVL-1:0] pred_mask,
    output logic             busy,
    output logic             done,
    output logic             step,
    output logic             step_active,
    output logic             step_last,
    output logic [IW-1:0]    it,
    output logic [1:0]       sub,
    output logic             c_mode,
    output logic [RAW-1:0]   c_sbase,
    output logic [RAW-1:0]   c_dbase,
    output logic [1:0]       c_swl,
    output logic [1:0]       c_dwl,
    output logic [1:0]       c_sub_m1
);
    seq_state_e       state;
    logic [VLW-1:0]   c_vl;
    logic [MAXVL-1:0] c_pred;
    logic [1:0]       ratio_log, ratio_m1, cnt_m1;
    logic             last_iter;

    // Sub-step count per active iteration and step qualifiers.
    always_comb begin
        if (c_mode == MODE_GATHER)
            ratio_log = (c_dwl > c_swl) ? (c_dwl - c_swl) : 2'd0;
        else
            ratio_log = (c_swl > c_dwl) ? (c_swl - c_dwl) : 2'd0;
        ratio_m1    = (ratio_log == 2'd0) ? 2'd0 : ((ratio_log == 2'd1) ? 2'd1 : 2'd3);
        cnt_m1      = (c_sub_m1 < ratio_m1) ? c_sub_m1 : ratio_m1;
        step        = (state == ST_RUN);
        step_active = c_pred[it];
        step_last   = !step_active || (sub == cnt_m1);
        last_iter   = (VLW'(it) == (c_vl - VLW'(1)));
        busy        = (state != ST_IDLE);
    end

    // Job latch, iteration counters and state sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            done     <= 1'b0;
            it       <= '0;
            sub      <= '0;
            c_vl     <= '0;
            c_pred   <= '0;
            c_mode   <= MODE_GATHER;
            c_sbase  <= '0;
            c_dbase  <= '0;
            c_swl    <= '0;
            c_dwl    <= '0;
            c_sub_m1 <= '0;
        end else begin
            done <= (state == ST_DRAIN);
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        c_vl     <= vec_len;
                        c_pred   <= pred_mask;
                        c_mode   <= mode;
                        c_sbase  <= src_base;
                        c_dbase  <= dst_base;
                        c_swl    <= ew_log(src_ew);
                        c_dwl    <= ew_log(dst_ew);
                        c_sub_m1 <= sub_len_m1;
                        it       <= '0;
                        sub      <= '0;
                        state    <= (vec_len == '0) ? ST_DRAIN : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (step_last) begin
                        sub <= '0;
                        if (last_iter) state <= ST_DRAIN;
                        else           it    <= it + IW'(1);
                    end else begin
                        sub <= sub + 2'd1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/svm_datapath.sv
`timescale 1ns/1ps
// svm_datapath: extracts the read element, packs or slices it, drives the write port.
// Assumes the source and destination regions of a job do not overlap.
module svm_datapath
    import svm_pkg::*;
#(
    parameter int RAW = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step,
    input  logic           active,
    input  logic           last,
    input  logic           mode,
    input  logic [1:0]     swl,
    input  logic [1:0]     dwl,
    input  logic [1:0]     sub,
    input  logic [1:0]     src_lane,
    input  logic [1:0]     dst_lane,
    input  logic [RAW-1:0] dst_reg,
    input  logic [31:0]    rd_data,
    output logic           wr_en,
    output logic [RAW-1:0] wr_reg,
    output logic [3:0]     wr_be,
    output logic [31:0]    wr_data
);
    logic [31:0] acc, piece, merged, val;
    logic [6:0]  sh_src, sh_dst;
    logic        issue;

    // Element extraction, group packing or slicing, and lane placement.
    always_comb begin
        piece  = (rd_data >> {src_lane, 3'b000}) & ew_mask(swl);
        sh_src = {2'b00, sub, 3'b000} << swl;
        sh_dst = {2'b00, sub, 3'b000} << dwl;
        merged = acc | (piece << sh_src);
        if (mode == MODE_GATHER) begin
            val   = merged & ew_mask(dwl);
            issue = step && active && last;
        end else begin
            val   = (piece >> sh_dst) & ew_mask(dwl);
            issue = step && active;
        end
    end

    // Group accumulator for gather mode, cleared at each iteration end.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  acc <= '0;
        else if (step && (mode == MODE_GATHER))      acc <= last ? '0 : merged;
    end

    // Registered write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_reg  <= '0;
            wr_be   <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= issue;
            if (issue) begin
                wr_reg  <= dst_reg;
                wr_be   <= ew_be(dwl) << dst_lane;
                wr_data <= val << {dst_lane, 3'b000};
            end
        end
    end
endmodule

// File: rtl/subvec_move_seq.sv
`timescale 1ns/1ps
// subvec_move_seq: top of the one-sided subvector pack/unpack move sequencer.
// Assumes a combinational read port and non-overlapping source and destination.
module subvec_move_seq
    import svm_pkg::*;
#(
    parameter int MAXVL = 8,
    parameter int RAW   = 7,
    localparam int VLW  = $clog2(MAXVL + 1),
    localparam int IW   = $clog2(MAXVL),
    localparam int IDXW = $clog2(MAXVL * 4)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VLW-1:0]   vec_len,
    input  logic [1:0]       sub_len_m1,
    input  logic             mode,
    input  logic [RAW-1:0]   src_base,
    input  logic [RAW-1:0]   dst_base,
    input  logic [1:0]       src_ew,
    input  logic [1:0]       dst_ew,
    input  logic [MAXVL-1:0] pred_mask,
    output logic             busy,
    output logic             done,
    output logic [RAW-1:0]   rd_reg,
    input  logic [31:0]      rd_data,
    output logic             wr_en,
    output logic [RAW-1:0]   wr_reg,
    output logic [3:0]       wr_be,
    output logic [31:0]      wr_data
);
    logic            step, step_active, step_last, c_mode;
    logic [IW-1:0]   it;
    logic [1:0]      sub, c_swl, c_dwl, c_sub_m1, src_lane, dst_lane;
    logic [RAW-1:0]  c_sbase, c_dbase, dst_reg;
    logic [IDXW-1:0] grp_idx, src_idx, dst_idx;

    svm_ctrl #(.MAXVL(MAXVL), .RAW(RAW), .VLW(VLW), .IW(IW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .vec_len(vec_len),
        .sub_len_m1(sub_len_m1), .mode(mode), .src_base(src_base),
        .dst_base(dst_base), .src_ew(src_ew), .dst_ew(dst_ew),
        .pred_mask(pred_mask), .busy(busy), .done(done), .step(step),
        .step_active(step_active), .step_last(step_last), .it(it), .sub(sub),
        .c_mode(c_mode), .c_sbase(c_sbase), .c_dbase(c_dbase),
        .c_swl(c_swl), .c_dwl(c_dwl), .c_sub_m1(c_sub_m1)
    );

    // Grouped-side index i*S+j and flat-side index i, routed by mode.
    always_comb begin
        grp_idx = IDXW'(it) * IDXW'({1'b0, c_sub_m1} + 3'd1) + IDXW'(sub);
        src_idx = (c_mode == MODE_GATHER) ? grp_idx : IDXW'(it);
        dst_idx = (c_mode == MODE_GATHER) ? IDXW'(it) : grp_idx;
    end

    svm_addr #(.RAW(RAW), .IDXW(IDXW)) u_src_addr (
        .base(c_sbase), .idx(src_idx), .ewl(c_swl), .reg_idx(rd_reg), .lane(src_lane)
    );

    svm_addr #(.RAW(RAW), .IDXW(IDXW)) u_dst_addr (
        .base(c_dbase), .idx(dst_idx), .ewl(c_dwl), .reg_idx(dst_reg), .lane(dst_lane)
    );

    svm_datapath #(.RAW(RAW)) u_dp (
        .clk(clk), .rst_n(rst_n), .step(step), .active(step_active),
        .last(step_last), .mode(c_mode), .swl(c_swl), .dwl(c_dwl), .sub(sub),
        .src_lane(src_lane), .dst_lane(dst_lane), .dst_reg(dst_reg),
        .rd_data(rd_data), .wr_en(wr_en), .wr_reg(wr_reg), .wr_be(wr_be),
        .wr_data(wr_data)
    );
endmodule

// File: rtl/svm_checker.sv
`timescale 1ns/1ps
// svm_checker: protocol properties of the move sequencer, bound to its top.
// Assumes dwl is the latched, clamped destination width of the running job.
module svm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       wr_en,
    input logic [3:0] wr_be,
    input logic [1:0] dwl
);
    // R7: done lasts a single cycle.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done comes right after the busy window closes.
    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R7: writes stay inside the busy window.
    assert_write_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);

    // R9: busy only starts from an accepted start pulse.
    assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R10: every write enables exactly the lanes of one destination element.
    assert_be_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($countones(wr_be) == (32'd1 << dwl)));
endmodule

bind subvec_move_seq svm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .wr_en(wr_en), .wr_be(wr_be), .dwl(c_dwl)
);

// File: tb/subvec_move_seq_test.sv
`timescale 1ns/1ps
// subvec_move_seq_test: self-checking bench with a byte-lane register file model.
module subvec_move_seq_test;
    localparam int MAXVL = 8;
    localparam int RAW   = 7;
    localparam int VLW   = $clog2(MAXVL + 1);
    localparam int RF_N  = 1 << RAW;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [VLW-1:0]   vec_len = '0;
    logic [1:0]       sub_len_m1 = '0;
    logic             mode = 1'b0;
    logic [RAW-1:0]   src_base = '0, dst_base = '0;
    logic [1:0]       src_ew = '0, dst_ew = '0;
    logic [MAXVL-1:0] pred_mask = '0;
    logic             busy, done, wr_en;
    logic [RAW-1:0]   rd_reg, wr_reg;
    logic [31:0]      rd_data, wr_data;
    logic [3:0]       wr_be;

    logic [31:0] rf   [RF_N];
    logic [31:0] pre  [RF_N];
    logic [31:0] expv [RF_N];
    int compared = 0, mismatched = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz
    assign rd_data = rf[rd_reg];

    subvec_move_seq #(.MAXVL(MAXVL), .RAW(RAW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .vec_len(vec_len),
        .sub_len_m1(sub_len_m1), .mode(mode), .src_base(src_base),
        .dst_base(dst_base), .src_ew(src_ew), .dst_ew(dst_ew),
        .pred_mask(pred_mask), .busy(busy), .done(done), .rd_reg(rd_reg),
        .rd_data(rd_data), .wr_en(wr_en), .wr_reg(wr_reg), .wr_be(wr_be),
        .wr_data(wr_data)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int width_bytes(input logic [1:0] code);
        return (code == 2'd3) ? 4 : (1 << code);
    endfunction

    function automatic logic [31:0] get_el(input int base, input int e, input int b);
        logic [31:0] v = 0;
        for (int k = 0; k < b; k++) begin
            int off = base * 4 + e * b + k;
            v |= 32'(pre[(off / 4) % RF_N][(off % 4) * 8 +: 8]) << (8 * k);
        end
        return v;
    endfunction

    task automatic put_el(input int base, input int e, input int b, input logic [31:0] v);
        for (int k = 0; k < b; k++) begin
            int off = base * 4 + e * b + k;
            expv[(off / 4) % RF_N][(off % 4) * 8 +: 8] = v[8 * k +: 8];
        end
    endtask

    // One job: randomize the file, build the reference, run, and compare.
    task automatic run_op(input logic md, input logic [1:0] sm1, input int v,
                          input logic [1:0] sc, input logic [1:0] dc,
                          input int sbase, input int dbase,
                          input logic [MAXVL-1:0] p, input bit inject, input string tag);
        int sb, db, s, cnt, steps, writes, n, nw, nb, bad, first;
        logic [31:0] val;
        for (int r = 0; r < RF_N; r++) begin
            rf[r] = $urandom; pre[r] = rf[r]; expv[r] = rf[r];
        end
        sb = width_bytes(sc); db = width_bytes(dc); s = sm1 + 1;
        if (md == 1'b0) cnt = (db > sb) ? db / sb : 1;
        else            cnt = (sb > db) ? sb / db : 1;
        if (cnt > s) cnt = s;
        steps = 0; writes = 0;
        for (int i = 0; i < v; i++) begin
            if (!p[i]) begin
                steps++;
            end else begin
                steps += cnt;
                writes += md ? cnt : 1;
                if (md == 1'b0) begin
                    val = 0;
                    for (int j = 0; j < cnt; j++)
                        val |= get_el(sbase, i * s + j, sb) << (8 * j * sb);
                    put_el(dbase, i, db, val);
                end else begin
                    val = get_el(sbase, i, sb);
                    for (int j = 0; j < cnt; j++)
                        put_el(dbase, i * s + j, db, val >> (8 * j * db));
                end
            end
        end
        mode = md; sub_len_m1 = sm1; vec_len = VLW'(v); src_ew = sc; dst_ew = dc;
        src_base = RAW'(sbase); dst_base = RAW'(dbase); pred_mask = p; start = 1'b1;
        n = 0; nw = 0; nb = 0;
        do begin
            @(negedge clk);
            n++;
            start = 1'b0;
            if (inject && n == 2) begin
                start = 1'b1; mode = ~md; vec_len = VLW'(1); pred_mask = '0;
            end
            if (wr_en) begin
                nw++;
                for (int k = 0; k < 4; k++)
                    if (wr_be[k]) rf[wr_reg][8 * k +: 8] = wr_data[8 * k +: 8];
            end
            if (busy) nb++;
        end while (!done && n < 1000);
        check(n == steps + 2, "R7", "cycles from start to done", n, steps + 2);
        check(nb == steps + 1, "R7", "busy cycles", nb, steps + 1);
        check(nw == writes, "R6", "write strobes", nw, writes);
        bad = 0; first = 0;
        for (int r = 0; r < RF_N; r++)
            if (rf[r] !== expv[r]) begin
                if (bad == 0) first = r;
                bad++;
            end
        check(bad == 0, tag, $sformatf("register %0d", first), rf[first], expv[first]);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            compared++; mismatched++;
            $display("FAIL R7 watchdog expired: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int r = 0; r < RF_N; r++) rf[r] = 0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !wr_en, "R1", "busy/done/wr_en in reset",
              {busy, done, wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !wr_en, "R1", "busy/done/wr_en after reset",
              {busy, done, wr_en}, 0);

        // R2: equal widths, strided source.
        run_op(1'b0, 2'd1, 4, 2'd2, 2'd2, 4, 70, 8'hFF, 0, "R2");
        // R3: equal widths, strided destination.
        run_op(1'b1, 2'd2, 5, 2'd1, 2'd1, 3, 66, 8'hFF, 0, "R3");
        // R4: four bytes packed into one word.
        run_op(1'b0, 2'd3, 6, 2'd0, 2'd2, 1, 80, 8'hFF, 0, "R4");
        // R4: three bytes into a word, top lane zero.
        run_op(1'b0, 2'd2, 7, 2'd0, 2'd2, 9, 72, 8'hFF, 0, "R4");
        // R3: word split into four bytes.
        run_op(1'b1, 2'd3, 8, 2'd2, 2'd0, 5, 64, 8'hFF, 0, "R3");
        // R3: word split into three bytes, fourth dropped.
        run_op(1'b1, 2'd2, 5, 2'd2, 2'd0, 6, 70, 8'hFF, 0, "R3");
        // R5: truncation of wider source, zero-extension of narrower one.
        run_op(1'b0, 2'd2, 6, 2'd2, 2'd0, 2, 68, 8'hFF, 0, "R5");
        run_op(1'b1, 2'd1, 6, 2'd0, 2'd2, 2, 68, 8'hFF, 0, "R5");
        // R6: sparse predicate.
        run_op(1'b0, 2'd3, 8, 2'd0, 2'd2, 0, 90, 8'b1010_0110, 0, "R6");
        run_op(1'b1, 2'd1, 8, 2'd1, 2'd0, 7, 77, 8'b0101_1001, 0, "R6");
        run_op(1'b1, 2'd3, 4, 2'd2, 2'd0, 7, 77, 8'h00, 0, "R6");
        // R8: subvector length one in both modes.
        run_op(1'b0, 2'd0, 8, 2'd1, 2'd1, 10, 75, 8'hFF, 0, "R8");
        run_op(1'b1, 2'd0, 8, 2'd1, 2'd1, 10, 75, 8'hFF, 0, "R8");
        run_op(1'b0, 2'd0, 5, 2'd0, 2'd1, 11, 75, 8'hFF, 0, "R8");
        // R7: zero vector length.
        run_op(1'b0, 2'd3, 0, 2'd0, 2'd2, 1, 80, 8'hFF, 0, "R7");
        // R9: start pulse during a job.
        run_op(1'b0, 2'd3, 8, 2'd0, 2'd1, 3, 82, 8'hFF, 1, "R9");
        // R10: reserved width code acts as 32 bits, base wraps the file.
        run_op(1'b1, 2'd1, 4, 2'd3, 2'd1, 20, 126, 8'hFF, 0, "R10");

        for (int t = 0; t < 40; t++) begin
            logic md = 1'($urandom % 2);
            run_op(md, 2'($urandom % 4), int'($urandom % (MAXVL + 1)),
                   2'($urandom % 3), 2'($urandom % 3), int'($urandom % 32),
                   64 + int'($urandom % 32), MAXVL'($urandom), 0, md ? "R3" : "R2");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule